// File: doc/BRIEF.md
# Pulse Wave Tone Channel

A single square-wave tone generator that runs from the system CPU clock. Software loads three byte-wide registers. The first sets volume, duty and a constant-level mode. The second and third set a 12-bit period, and the third also carries the channel enable. A down-counting divider reloads from the period each time it reaches zero. Each reload advances a 16-position duty sequencer by one step. The sequencer counts down from 15 to 0. The 4-bit sample output carries the volume while the current step is no greater than the duty value, and zero at all other steps.

Two inputs come from a frequency-scaling control that several channels share. A halt input freezes the divider and the sequencer where they stand. Two rate inputs shorten the effective period by a right shift of 4 or 8 bits, which raises the pitch by four or eight octaves. Clearing the enable silences the channel and parks the sequencer at its first step. Setting the enable again restarts the waveform from a known phase.

Top module: `pulse_tone_channel`

## Requirements
- R1: Reset clears the volume, duty, mode, period and enable to 0, clears the divider to 0 and parks the sequencer at step 15, so `sample` reads 0.
- R2: A write with `wr_sel`=0 loads the control register: bit 7 is the constant-level mode, bits 6:4 are the duty D, and bits 3:0 are the volume V.
- R3: A write with `wr_sel`=1 loads period bits 7:0. A write with `wr_sel`=2 loads period bits 11:8 from data bits 3:0 and the enable from data bit 7.
- R4: On every clock without halt, the divider decrements by one. When it is zero, it instead reloads the effective period and advances the sequencer by one step.
- R5: The sequencer steps 15, 14, … 0 and then wraps to 15. While enabled, `sample` equals V when step ≤ D and 0 otherwise, so the high fraction is (D+1)/16.
- R6: With the mode bit set and the channel enabled, `sample` equals V on every cycle, whatever the step.
- R7: While the enable is 0, `sample` is 0 and the step is held at 15. After the enable is set, the first output step is 15, so with period 0 the first nonzero sample for D=0 appears 15 cycles later.
- R8: One full waveform lasts 16×(P+1) clocks, where P is the effective period, and each step lasts P+1 clocks.
- R9: While `halt` is 1, the divider count and the sequencer step do not change. When `halt` returns to 0, counting resumes from the frozen state.
- R10: With `rate_sh4`=1, the effective period is P>>4. With `rate_sh8`=1, it is P>>8, and this takes priority over `rate_sh4`.
- R11: A period write does not restart the count in progress. The new value is first used at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period low, 2 period high and enable |
| wr_data | input | 8 | Write data |
| halt | input | 1 | Freeze divider and sequencer |
| rate_sh4 | input | 1 | Use period shifted right by 4 |
| rate_sh8 | input | 1 | Use period shifted right by 8, overrides `rate_sh4` |
| sample | output | 4 | Channel sample |

## Verification
The assertions check these properties on every clock:
- The divider only decrements or reloads from zero.
- The step moves only by a single decrement, and only after a divider zero with no halt.
- A halt freezes both counters.
- A cleared enable parks the step at 15.
- An enable-clearing write silences the next sample.

The following can only be shown by the bench scenarios, which compare output sums and run lengths:
- The duty ratios for each D.
- The 16×(P+1) waveform period.
- The shift priority.
- The deferred effect of a period write.
- The exact 15-cycle delay before the first high step after enabling.

// File: rtl/pulse_tone_pkg.sv
package pulse_tone_pkg;

   // register select codes on the write port
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_PLO  = 2'd1,
      SEL_PHI  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/pulse_tone_regs.sv
module pulse_tone_regs
   import pulse_tone_pkg::*;
#(
   parameter int PERIOD_W = 12,
   parameter int DATA_W   = 8,
   parameter int VOL_W    = 4,
   parameter int DUTY_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [1:0]          wr_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                mode,
   output logic [DUTY_W-1:0]   duty,
   output logic [VOL_W-1:0]    vol,
   output logic [PERIOD_W-1:0] period,
   output logic                enable
);

   localparam int HI_W   = PERIOD_W - DATA_W;
   localparam int EN_BIT = DATA_W - 1;

   generate
      if (HI_W < 1 || HI_W > DATA_W - 1) begin : g_bad_hi
         $error("period high part must fit below the enable bit");
      end
      if (VOL_W + DUTY_W + 1 > DATA_W) begin : g_bad_ctrl
         $error("control fields exceed the data width");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode   <= 1'b0;
         duty   <= '0;
         vol    <= '0;
         period <= '0;
         enable <= 1'b0;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            SEL_CTRL: begin
               mode <= wr_data[DATA_W-1];
               duty <= wr_data[VOL_W +: DUTY_W];
               vol  <= wr_data[VOL_W-1:0];
            end
            SEL_PLO: period[DATA_W-1:0] <= wr_data;
            SEL_PHI: begin
               period[PERIOD_W-1:DATA_W] <= wr_data[HI_W-1:0];
               enable                    <= wr_data[EN_BIT];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pulse_tone_divider.sv
module pulse_tone_divider #(
   parameter int PERIOD_W = 12,
   parameter int SHIFT_A  = 4,
   parameter int SHIFT_B  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                halt,
   input  logic                sh_a,
   input  logic                sh_b,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick,
   output logic [PERIOD_W-1:0] cnt
);

   localparam logic [PERIOD_W-1:0] CNT_ONE = {{(PERIOD_W-1){1'b0}}, 1'b1};

   generate
      if (SHIFT_A < 1 || SHIFT_A >= SHIFT_B || SHIFT_B >= PERIOD_W) begin : g_bad_shift
         $error("shift amounts must satisfy 0 < A < B < period width");
      end
   endgenerate

   logic [PERIOD_W-1:0] eff_period;
   logic [PERIOD_W-1:0] cnt_q;

   // larger shift wins over the smaller one
   always_comb begin
      if (sh_b)      eff_period = period >> SHIFT_B;
      else if (sh_a) eff_period = period >> SHIFT_A;
      else           eff_period = period;
   end

   assign tick = (cnt_q == '0) && !halt;
   assign cnt  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!halt) begin
         if (cnt_q == '0)       cnt_q <= eff_period;
         else                   cnt_q <= cnt_q - CNT_ONE;
      end
   end

endmodule

// File: rtl/pulse_tone_seq.sv
module pulse_tone_seq #(
   parameter int STEP_W  = 4,
   parameter int DUTY_W  = 3,
   parameter int VOL_W   = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              mode,
   input  logic [DUTY_W-1:0] duty,
   input  logic [VOL_W-1:0]  vol,
   output logic [STEP_W-1:0] step,
   output logic [VOL_W-1:0]  sample
);

   localparam logic [STEP_W-1:0] STEP_TOP = {STEP_W{1'b1}};
   localparam logic [STEP_W-1:0] STEP_ONE = {{(STEP_W-1){1'b0}}, 1'b1};

   generate
      if (DUTY_W >= STEP_W) begin : g_bad_duty
         $error("duty field must be narrower than the step counter");
      end
   endgenerate

   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] duty_ext;
   logic              level_on;
   logic [VOL_W-1:0]  sample_d;

   assign duty_ext = {{(STEP_W-DUTY_W){1'b0}}, duty};
   assign level_on = enable && (mode || (step_q <= duty_ext));
   assign sample_d = level_on ? vol : '0;
   assign step     = step_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) step_q <= STEP_TOP;
      else if (tick)         step_q <= step_q - STEP_ONE;
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic [VOL_W-1:0] sample_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sample_q <= '0;
            else        sample_q <= sample_d;
         end
         assign sample = sample_q;
      end else begin : g_out_comb
         assign sample = sample_d;
      end
   endgenerate

endmodule

// File: rtl/pulse_tone_channel.sv
module pulse_tone_channel #(
   parameter int PERIOD_W = 12,
   parameter int DATA_W   = 8,
   parameter int VOL_W    = 4,
   parameter int DUTY_W   = 3,
   parameter int STEP_W   = 4,
   parameter int SHIFT_A  = 4,
   parameter int SHIFT_B  = 8,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              halt,
   input  logic              rate_sh4,
   input  logic              rate_sh8,
   output logic [VOL_W-1:0]  sample
);

   logic                mode_w;
   logic [DUTY_W-1:0]   duty_w;
   logic [VOL_W-1:0]    vol_w;
   logic [PERIOD_W-1:0] period_w;
   logic                en_w;
   logic                tick_w;
   logic [PERIOD_W-1:0] cnt_w;
   logic [STEP_W-1:0]   step_w;

   pulse_tone_regs #(
      .PERIOD_W(PERIOD_W), .DATA_W(DATA_W), .VOL_W(VOL_W), .DUTY_W(DUTY_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mode(mode_w), .duty(duty_w), .vol(vol_w), .period(period_w), .enable(en_w)
   );

   pulse_tone_divider #(
      .PERIOD_W(PERIOD_W), .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .halt(halt), .sh_a(rate_sh4), .sh_b(rate_sh8),
      .period(period_w), .tick(tick_w), .cnt(cnt_w)
   );

   pulse_tone_seq #(
      .STEP_W(STEP_W), .DUTY_W(DUTY_W), .VOL_W(VOL_W), .OUT_REG(OUT_REG)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .enable(en_w), .tick(tick_w), .mode(mode_w),
      .duty(duty_w), .vol(vol_w), .step(step_w), .sample(sample)
   );

endmodule

// File: rtl/pulse_tone_chk.sv
module pulse_tone_chk #(
   parameter int PERIOD_W = 12,
   parameter int DATA_W   = 8,
   parameter int VOL_W    = 4,
   parameter int STEP_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [1:0]          wr_sel,
   input logic [DATA_W-1:0]   wr_data,
   input logic                halt,
   input logic                en,
   input logic [STEP_W-1:0]   step,
   input logic [PERIOD_W-1:0] cnt,
   input logic [VOL_W-1:0]    sample
);

   localparam logic [PERIOD_W-1:0] C_ONE = {{(PERIOD_W-1){1'b0}}, 1'b1};
   localparam logic [STEP_W-1:0]   S_ONE = {{(STEP_W-1){1'b0}}, 1'b1};

   // R7
   dis_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !wr_data[DATA_W-1]) |=> (sample == '0));

   // R7
   dis_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (step == {STEP_W{1'b1}}));

   // R9
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && en) |=> ($stable(step) && $stable(cnt)));

   // R4
   cnt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> ((cnt == $past(cnt) - C_ONE) || ($past(cnt) == '0)));

   // R5
   step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && step != $past(step)) |-> (step == $past(step) - S_ONE));

   // R4
   step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && step != $past(step)) |-> (($past(cnt) == '0) && !$past(halt)));

endmodule

bind pulse_tone_channel pulse_tone_chk #(
   .PERIOD_W(PERIOD_W), .DATA_W(DATA_W), .VOL_W(VOL_W), .STEP_W(STEP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .halt(halt), .en(en_w), .step(step_w), .cnt(cnt_w), .sample(sample)
);

// File: tb/pulse_tone_channel_tb.sv
`timescale 1ns/1ps
module pulse_tone_channel_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       halt = 1'b0;
   logic       rate_sh4 = 1'b0;
   logic       rate_sh8 = 1'b0;
   logic [3:0] sample;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pulse_tone_channel u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .halt(halt), .rate_sh4(rate_sh4), .rate_sh8(rate_sh8), .sample(sample)
   );

   // {control byte, period, expected sample sum over 16*(P+1) cycles}
   localparam logic [31:0] VECS [0:7] = '{
      {8'h0F, 12'd0, 12'd15},
      {8'h3A, 12'd0, 12'd40},
      {8'h75, 12'd1, 12'd80},
      {8'h84, 12'd0, 12'd64},
      {8'hF9, 12'd2, 12'd432},
      {8'h50, 12'd1, 12'd0},
      {8'h23, 12'd3, 12'd36},
      {8'h6C, 12'd2, 12'd252}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic high_run(output int n);
      n = 0;
      while (sample != 0) @(negedge clk);
      while (sample == 0) @(negedge clk);
      while (sample != 0) begin
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int sum, n;
      bit ok;
      logic [3:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sample == 0, "R1 reset sample", sample, 0);

      // R2 R3 R5 R6 table of duty/volume/period patterns
      for (int i = 0; i < 8; i++) begin
         wr(2'd0, VECS[i][31:24]);
         wr(2'd1, VECS[i][19:12]);
         wr(2'd2, {1'b1, 3'b000, VECS[i][23:20]});
         repeat (16) @(negedge clk);
         sum = 0;
         for (int c = 0; c < 16 * (int'(VECS[i][23:12]) + 1); c++) begin
            sum += int'(sample);
            @(negedge clk);
         end
         chk(sum == int'(VECS[i][11:0]), "R5 duty sum", sum, int'(VECS[i][11:0]));
      end

      // R6 mode forces volume, R7 disable forces zero
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h8F);
      chk(sample == 4'hF, "R6 constant level", sample, 15);
      wr(2'd2, 8'h00);
      chk(sample == 0, "R7 disabled output", sample, 0);

      // R7 restart from step 15: D=0 V=8, period 0
      wr(2'd0, 8'h08);
      repeat (4) @(negedge clk);
      wr(2'd2, 8'h80);
      ok = 1'b1;
      for (int k = 0; k < 15; k++) begin
         if (sample != 0) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R7 leading zeros after enable", ok, 1);
      chk(sample == 4'h8, "R7 first high after 15 steps", sample, 8);

      // R8 frequency: D=7 V=1 P=5 -> high run of 8*6
      wr(2'd0, 8'h71);
      wr(2'd1, 8'h05);
      wr(2'd2, 8'h80);
      high_run(n);
      chk(n == 48, "R8 high run length", n, 48);

      // R10 shift by 4
      wr(2'd1, 8'hF0);
      rate_sh4 = 1'b1;
      high_run(n);
      chk(n == 128, "R10 shift by 4", n, 128);

      // R10 shift by 8, and priority over shift by 4
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h85);
      rate_sh4 = 1'b0;
      rate_sh8 = 1'b1;
      high_run(n);
      chk(n == 48, "R10 shift by 8", n, 48);
      rate_sh4 = 1'b1;
      high_run(n);
      chk(n == 48, "R10 shift by 8 wins", n, 48);
      rate_sh4 = 1'b0;
      rate_sh8 = 1'b0;

      // R9 halt freezes state
      wr(2'd2, 8'h80);
      wr(2'd1, 8'h00);
      repeat (5) @(negedge clk);
      halt = 1'b1;
      @(negedge clk);
      held = sample;
      ok = 1'b1;
      for (int k = 0; k < 40; k++) begin
         if (sample != held) ok = 1'b0;
         @(negedge clk);
      end
      chk(ok, "R9 output frozen under halt", ok, 1);
      halt = 1'b0;
      ok = 1'b0;
      for (int k = 0; k < 17; k++) begin
         if (sample != held) ok = 1'b1;
         @(negedge clk);
      end
      chk(ok, "R9 resumes after halt", ok, 1);

      // R11 period write defers to the next reload: P=32 then lo=0 mid-step
      wr(2'd1, 8'h20);
      while (sample != 0) @(negedge clk);
      while (sample == 0) @(negedge clk);
      n = 1;
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h00;
      @(negedge clk);
      wr_en = 1'b0;
      while (sample != 0) begin
         n++;
         @(negedge clk);
      end
      chk(n == 40, "R11 deferred period", n, 40);

      // R1 reset mid-run clears control
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(sample == 0, "R1 sample after reset", sample, 0);
      wr(2'd2, 8'h80);
      repeat (20) @(negedge clk);
      chk(sample == 0, "R1 volume cleared by reset", sample, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule